// File: doc/BRIEF.md
# 64-bit Timebase with Snapshot Register

This block is a continuously running 64-bit cycle counter that a processor uses as its system time source. A register port with 32-bit data gives access to it. Software could read the two live halves one at a time, but a carry can land between the two reads. For a consistent value, software writes a capture command to the control register. That copies the whole 64-bit count into a pair of shadow words in one clock edge, and software then reads the shadow words at leisure.

The same control register also carries a preload command. It copies a 64-bit value, staged beforehand in two load words, into the counter. This is used, for example, to put time back after the system has been powered down. A persistent divider field in the control register sets the count rate. A field of zero makes the counter advance on every clock.

Top module: `timebase64`

## Requirements
- R1: While reset is high and right after it, the control register, both live words, both load words and both snapshot words all read as zero.
- R2: With divider field 0, the 64-bit count rises by exactly one on every clock edge that carries no control write.
- R3: With divider field N (control bits 9 to 2), the count rises by one every N+1 cycles. Any control write restarts that cycle phase.
- R4: A control write with bit 0 set and bit 1 clear copies the count present at that edge into the snapshot words (low at 0x7C, high at 0x80). The snapshot words then keep that value until the next such write.
- R5: A control write with bits 0 and 1 both set makes the count equal the 64-bit load value (load low at 0x74, load high at 0x78) after that edge. Counting then continues upward from the loaded value.
- R6: The control register is at 0x68. Bits 0 and 1 act only as command strobes and always read back as 0. The divider field keeps its written value until the next control write.
- R7: The count wraps from all ones to zero, and the high word follows the carry.
- R8: Writes to the live words (low at 0x6C, high at 0x70) or to the snapshot words change nothing. A control write with bit 1 set and bit 0 clear neither loads nor captures.
- R9: The load words can be written and read back at their addresses, and each write touches only its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 8 | Byte address of the register to write or read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The count is run with no divider and with small nonzero dividers. This separates a counter that steps every cycle from one that steps at the programmed rate, and it exposes a divider phase that fails to restart on a control write. Capture commands are issued while the count is moving. A shadow copy taken one cycle early or late, or one that drifts afterwards, then shows up against the value read just before the command. A preload near the top of the range exposes both a wrong load value and a missing carry into the high word. Random mixes of load-word writes, commands, rate changes and writes to read-only addresses are checked word by word against a bench model after every step.

// File: rtl/timebase_pkg.sv
`timescale 1ns/100ps
package timebase_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int NWORDS = CNT_W / DATA_W;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 8;

    localparam int CTL_SNAP_BIT = 0;
    localparam int CTL_LOAD_BIT = 1;
    localparam int CTL_DIV_LSB  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_LIVE = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_SNAP = 8'h7C;

    typedef logic [CNT_W-1:0]  count_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [DIV_W-1:0]  div_t;

    typedef struct packed {
        logic wr;     // control register written this cycle
        logic snap;   // capture command
        logic load;   // preload command
        div_t div;    // new divider value
    } ctl_cmd_t;

    function automatic logic [ADDR_W-1:0] word_ofs(input logic [ADDR_W-1:0] base, input int idx);
        return base + ADDR_W'(idx * (DATA_W / 8));
    endfunction

    function automatic ctl_cmd_t decode_ctl(input logic wr, input word_t d);
        ctl_cmd_t c;
        c.wr   = wr;
        c.snap = wr && d[CTL_SNAP_BIT] && !d[CTL_LOAD_BIT];
        c.load = wr && d[CTL_SNAP_BIT] && d[CTL_LOAD_BIT];
        c.div  = d[CTL_DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/timebase_prescale.sv
`timescale 1ns/100ps
module timebase_prescale
    import timebase_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  div_t div,
    output logic tick
);
    div_t phase_q;

    assign tick = (phase_q == div);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) phase_q <= '0;
        else                         phase_q <= phase_q + div_t'(1);
    end
endmodule

// File: rtl/timebase_counter.sv
`timescale 1ns/100ps
module timebase_counter
    import timebase_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  count_t load_val,
    output count_t cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= cnt + count_t'(1);
    end
endmodule

// File: rtl/timebase_snapshot.sv
`timescale 1ns/100ps
module timebase_snapshot
    import timebase_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  count_t cnt,
    output count_t snap
);
    always_ff @(posedge clk) begin
        if (rst)          snap <= '0;
        else if (capture) snap <= cnt;
    end
endmodule

// File: rtl/timebase_regs.sv
`timescale 1ns/100ps
module timebase_regs
    import timebase_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  word_t               wdata,
    input  count_t              cnt,
    input  count_t              snap,
    output ctl_cmd_t            cmd,
    output div_t                div,
    output count_t              load_val,
    output word_t               rdata
);
    word_t load_q [NWORDS];

    assign cmd = decode_ctl(wr_en && (addr == OFS_CTRL), wdata);

    always_ff @(posedge clk) begin
        if (rst)         div <= '0;
        else if (cmd.wr) div <= cmd.div;
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_load
        always_ff @(posedge clk) begin
            if (rst) load_q[w] <= '0;
            else if (wr_en && addr == word_ofs(OFS_LOAD, w)) load_q[w] <= wdata;
        end
        assign load_val[w*DATA_W +: DATA_W] = load_q[w];
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) rdata[CTL_DIV_LSB +: DIV_W] = div;
        for (int w = 0; w < NWORDS; w++) begin
            if (addr == word_ofs(OFS_LIVE, w)) rdata = cnt[w*DATA_W +: DATA_W];
            if (addr == word_ofs(OFS_LOAD, w)) rdata = load_q[w];
            if (addr == word_ofs(OFS_SNAP, w)) rdata = snap[w*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/timebase64.sv
`timescale 1ns/100ps
module timebase64
    import timebase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    ctl_cmd_t cmd;
    div_t     div_q;
    count_t   cnt_q;
    count_t   snap_q;
    count_t   load_val;
    logic     tick;

    timebase_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt_q), .snap(snap_q), .cmd(cmd), .div(div_q),
        .load_val(load_val), .rdata(rdata)
    );

    timebase_prescale u_pre (
        .clk(clk), .rst(rst), .restart(cmd.wr), .div(div_q), .tick(tick)
    );

    timebase_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(cmd.load),
        .load_val(load_val), .cnt(cnt_q)
    );

    timebase_snapshot u_snap (
        .clk(clk), .rst(rst), .capture(cmd.snap), .cnt(cnt_q), .snap(snap_q)
    );
endmodule

// File: rtl/timebase64_chk.sv
`timescale 1ns/100ps
module timebase64_chk
    import timebase_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input count_t            cnt,
    input count_t            snap,
    input count_t            load_val,
    input div_t              div
);
    logic ctl_w, snap_w, load_w;
    assign ctl_w  = wr_en && (addr == OFS_CTRL);
    assign snap_w = ctl_w && wdata[0] && !wdata[1];
    assign load_w = ctl_w && wdata[0] && wdata[1];

    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (rst)
        snap_w |=> snap == $past(cnt)); // R4
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !snap_w |=> snap == $past(snap)); // R4
    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (rst)
        load_w |=> cnt == $past(load_val)); // R5
    AST_UNDIV_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ctl_w && div == '0) |=> cnt == $past(cnt) + count_t'(1)); // R2
    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        !ctl_w |=> (cnt == $past(cnt) || cnt == $past(cnt) + count_t'(1))); // R3
    AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_CTRL) |-> rdata[1:0] == 2'b00); // R6
endmodule

bind timebase64 timebase64_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt(cnt_q), .snap(snap_q), .load_val(load_val), .div(div_q)
);

// File: tb/tb_timebase64.sv
`timescale 1ns/100ps
module tb_timebase64;
    import timebase_pkg::*;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [7:0]  addr = OFS_CTRL;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    timebase64 dut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

    always #2.5 clk = ~clk;

    // reference model, updated from the requirements on each rising edge
    logic [63:0] m_cnt = 0, m_lat = 0, m_ld = 0;
    logic [7:0]  m_div = 0, m_pre = 0;

    always @(posedge clk) begin
        logic ctl, tk;
        if (rst) begin
            m_cnt = 0; m_lat = 0; m_ld = 0; m_div = 0; m_pre = 0;
        end else begin
            ctl = wr_en && addr == 8'h68;
            tk  = (m_pre == m_div);
            if (ctl && wdata[0] && !wdata[1]) m_lat = m_cnt;
            if (ctl && wdata[0] && wdata[1]) m_cnt = m_ld;
            else if (tk) m_cnt = m_cnt + 64'd1;
            if (ctl || tk) m_pre = 0; else m_pre = m_pre + 8'd1;
            if (ctl) m_div = wdata[9:2];
            if (wr_en && addr == 8'h74) m_ld[31:0]  = wdata;
            if (wr_en && addr == 8'h78) m_ld[63:32] = wdata;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h68: return {22'd0, m_div, 2'b00};
            8'h6C: return m_cnt[31:0];
            8'h70: return m_cnt[63:32];
            8'h74: return m_ld[31:0];
            8'h78: return m_ld[63:32];
            8'h7C: return m_lat[31:0];
            8'h80: return m_lat[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; #0.2; v = rdata;
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo); rd(a + 8'd4, hi); v = {hi, lo};
    endtask

    task automatic check_all();
        for (int i = 0; i < 7; i++) begin
            logic [7:0]  a;
            logic [31:0] v;
            string tag;
            a = 8'h68 + 8'(4 * i);
            rd(a, v);
            tag = (i == 0) ? "R6" : (i < 3) ? "R2" : (i < 5) ? "R9" : "R4";
            check(tag, {32'd0, v}, {32'd0, exp_read(a)});
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] v, c0, c1;
        logic [31:0] w;
        void'($urandom(32'd20240611));

        // R1: reset state
        idle(3);
        for (int i = 0; i < 7; i++) begin
            rd(8'h68 + 8'(4 * i), w);
            check("R1", {32'd0, w}, 64'd0);
        end
        rst = 0;
        @(negedge clk);
        check_all();

        // R2: undivided step
        idle(5);
        rd64(8'h6C, c0);
        idle(1);
        rd64(8'h6C, c1);
        check("R2", c1, c0 + 64'd1);

        // R9: load words
        wr(8'h74, 32'hFFFF_FFFE);
        wr(8'h78, 32'hFFFF_FFFF);
        rd64(8'h74, v);
        check("R9", v, 64'hFFFF_FFFF_FFFF_FFFE);

        // R5 and R7: preload near top, wrap
        wr(8'h68, 32'h3);
        rd64(8'h6C, v);
        check("R5", v, 64'hFFFF_FFFF_FFFF_FFFE);
        idle(1);
        rd64(8'h6C, v);
        check("R5", v, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(1);
        rd64(8'h6C, v);
        check("R7", v, 64'd0);
        check_all();

        // R4: capture the value seen just before the command edge
        idle(3);
        @(negedge clk);
        rd64(8'h6C, c0);
        wr_en = 1; addr = 8'h68; wdata = 32'h1;
        @(negedge clk);
        wr_en = 0;
        rd64(8'h7C, v);
        check("R4", v, c0);
        idle(7);
        rd64(8'h7C, v);
        check("R4", v, c0);

        // R3 and R6: divider of 3
        wr(8'h68, 32'h0000_000C);
        rd(8'h68, w);
        check("R6", {32'd0, w}, 64'h0C);
        rd64(8'h6C, c0);
        idle(4);
        rd64(8'h6C, c1);
        check("R3", c1, c0 + 64'd1);
        check_all();

        // R6: strobe bit reads back zero, divider persists
        wr(8'h68, 32'h0000_000D);
        rd(8'h68, w);
        check("R6", {32'd0, w}, 64'h0C);
        check_all();

        // R8: bit 1 alone and writes to read-only words
        rd64(8'h7C, c0);
        wr(8'h68, 32'h0000_000E);
        rd64(8'h7C, v);
        check("R8", v, c0);
        wr(8'h6C, 32'h1234_5678);
        wr(8'h70, 32'h9ABC_DEF0);
        wr(8'h7C, 32'h5555_5555);
        wr(8'h80, 32'hAAAA_AAAA);
        rd64(8'h7C, v);
        check("R8", v, c0);
        rd64(8'h6C, v);
        check("R8", v, m_cnt);
        check_all();

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [31:0] dv;
            op = $urandom_range(0, 6);
            dv = {22'd0, 8'($urandom_range(0, 3)), 2'b00};
            case (op)
                0: wr(8'h74, $urandom);
                1: wr(8'h78, $urandom);
                2: wr(8'h68, dv | 32'h1);
                3: wr(8'h68, dv | 32'h3);
                4: wr(8'h68, dv | 32'($urandom_range(0, 1) * 2));
                5: wr(($urandom_range(0, 1) == 1) ? 8'h6C + 8'(4 * $urandom_range(0, 1))
                                                  : 8'h7C + 8'(4 * $urandom_range(0, 1)), $urandom);
                default: idle($urandom_range(1, 5));
            endcase
            check_all();
        end

        finish_run();
    end
endmodule